// File: doc/BRIEF.md
# Privileged Control Register Write Guard

This block is the access front end for the model-specific register instructions of a processor core. A request carries a 32-bit index, a direction and, for writes, a value in two 32-bit halves. The block checks privilege and the index range, then applies per-register write rules. Each accepted request produces exactly one response: a fault, or for a legal write a write-accept strobe, or for a legal read the data as a low/high pair.

The block holds three kinds of state itself. The first is an extended-feature enable register. The second is a feature-control register that can be locked. The third is a bank of address registers. Cross-register interlocks are enforced here. The long-mode enable bit cannot change while paging is on. The long-mode active bit cannot be written. The lock bit seals the feature-control register. What these registers do elsewhere in the core is outside this block.

Requests use a valid/ready handshake and responses use another. Only one request is in flight at a time. A request is taken when `req_valid && req_ready`. `req_ready` is high when no response is waiting, or when the waiting response is being consumed in the same cycle. A response stays on its pins, unchanged, until `rsp_ready` is high at a clock edge.

Top module: `ctlreg_access_guard`

## Requirements
- R1: An access faults when `real_mode` is 0 and `cpl` is not 0. In real mode any `cpl` is allowed.
- R2: An access faults when bits 29:0 of the index are at or above `IDX_LIMIT` (default 0x1000).
- R3: An index that is in range but matches no implemented register faults, both on read and on write, and changes no register. The implemented indices are 0x080 for the enable register, 0x03A for feature control, and 0x100 upward for `NUM_ADDR` address registers. All 32 index bits must match.
- R4: A write value is `{req_hi, req_lo}`. A successful read returns bits 31:0 on `rsp_lo` and bits 63:32 on `rsp_hi`. Faults and writes return zero data.
- R5: An enable-register write faults, leaving the register unchanged, if it sets any bit outside `EN_SUPPORTED` (default bits 0, 8, 10 and 11).
- R6: An enable-register write faults when `paging_on` is 1 and bit 8 of the value differs from the stored bit 8. A write that keeps bit 8 the same is accepted.
- R7: Bit 10 of the enable register (long-mode active) keeps its stored value on every write, whatever value is written. Its reset value is 0.
- R8: Once bit 0 of the feature-control register is 1, every write to it faults. Only the low 32 bits are stored, and a read returns 0 in the high half.
- R9: An address-register write faults unless bits 63:47 of the value are all equal (canonical). A canonical value is stored in full.
- R10: Every accepted request gives exactly one response, due on the next cycle. A write response has exactly one of `rsp_fault` and `rsp_wack` set. A read never sets `rsp_wack`. The response and its data stay stable while `rsp_ready` is 0, and `req_ready` is 0 during that time.
- R11: After reset no response is pending and every held register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_index | input | 32 | Register index |
| req_lo | input | 32 | Write value, bits 31:0 |
| req_hi | input | 32 | Write value, bits 63:32 |
| real_mode | input | 1 | Processor is in real mode |
| cpl | input | 2 | Current privilege level |
| paging_on | input | 1 | Paging is enabled |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 1 | Access faulted |
| rsp_wack | output | 1 | Write accepted and committed |
| rsp_lo | output | 32 | Read data, bits 31:0 |
| rsp_hi | output | 32 | Read data, bits 63:32 |

## Verification
A request accepted at one clock edge has its response registered at that same edge. It is therefore sampled at the following falling edge. A legal write updates its register at that same edge, so the next request already sees the new value. The bench drives each request for exactly one cycle and then checks the response. It then holds `rsp_ready` low for a chosen number of cycles and checks at each falling edge that the response is held and `req_ready` is low. Finally it pops the response and checks that `rsp_valid` has dropped before the next request starts.

// File: rtl/ctlreg_guard_pkg.sv
package ctlreg_guard_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned HW = 32;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_FEAT   = 2'd2,
    SEL_ADDR   = 2'd3
  } sel_e;
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_guard_pkg::*;
#(
  parameter logic [29:0] IDX_LIMIT = 30'h0000_1000,
  parameter logic [31:0] IDX_EN    = 32'h0000_0080,
  parameter logic [31:0] IDX_FC    = 32'h0000_003A,
  parameter logic [31:0] IDX_AB    = 32'h0000_0100,
  parameter int unsigned NUM_ADDR  = 4,
  localparam int unsigned SW       = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic [31:0]   index,
  output sel_e          sel,
  output logic [SW-1:0] slot,
  output logic          out_of_range
);
  always_comb begin
    out_of_range = (index[29:0] >= IDX_LIMIT);
    sel  = SEL_NONE;
    slot = '0;
    if (index == IDX_EN) begin
      sel = SEL_ENABLE;
    end else if (index == IDX_FC) begin
      sel = SEL_FEAT;
    end else begin
      for (int i = 0; i < NUM_ADDR; i++) begin
        if (index == IDX_AB + 32'(i)) begin
          sel  = SEL_ADDR;
          slot = SW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/ctlreg_enable_reg.sv
module ctlreg_enable_reg
  import ctlreg_guard_pkg::*;
#(
  parameter logic [DW-1:0] EN_SUPPORTED = 64'h0000_0000_0000_0D01,
  parameter int unsigned   LME_BIT      = 8,
  parameter int unsigned   LMA_BIT      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [DW-1:0] wdata,
  input  logic          paging_on,
  output logic [DW-1:0] value,
  output logic          bad
);
  localparam logic [DW-1:0] LMA_MASK = DW'(1) << LMA_BIT;

  logic [DW-1:0] en_q;
  logic reserved_hit, lme_flip;

  always_comb begin
    reserved_hit = |(wdata & ~EN_SUPPORTED);
    lme_flip     = paging_on && (wdata[LME_BIT] != en_q[LME_BIT]);
    bad          = reserved_hit || lme_flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (commit) begin
      en_q <= (wdata & EN_SUPPORTED & ~LMA_MASK) | (en_q & LMA_MASK);
    end
  end

  assign value = en_q;
endmodule

// File: rtl/ctlreg_feat_reg.sv
module ctlreg_feat_reg
  import ctlreg_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [HW-1:0] wdata,
  output logic [HW-1:0] value,
  output logic          bad
);
  logic [HW-1:0] fc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q <= '0;
    end else if (commit) begin
      fc_q <= wdata;
    end
  end

  assign bad   = fc_q[0];
  assign value = fc_q;
endmodule

// File: rtl/ctlreg_addr_bank.sv
module ctlreg_addr_bank
  import ctlreg_guard_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  parameter int unsigned VA_MSB   = 47,
  localparam int unsigned SW      = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [SW-1:0] slot,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bad
);
  logic [DW-1:0] regs [NUM_ADDR];
  logic [DW-1:VA_MSB] top_bits;

  assign top_bits = wdata[DW-1:VA_MSB];
  assign bad      = !((&top_bits) || !(|top_bits));

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (commit && (slot == SW'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_ADDR; i++) begin
      if (slot == SW'(i)) rdata = regs[i];
    end
  end
endmodule

// File: rtl/ctlreg_access_guard.sv
module ctlreg_access_guard
  import ctlreg_guard_pkg::*;
#(
  parameter logic [29:0]   IDX_LIMIT    = 30'h0000_1000,
  parameter logic [31:0]   IDX_EN       = 32'h0000_0080,
  parameter logic [31:0]   IDX_FC       = 32'h0000_003A,
  parameter logic [31:0]   IDX_AB       = 32'h0000_0100,
  parameter int unsigned   NUM_ADDR     = 4,
  parameter int unsigned   VA_MSB       = 47,
  parameter logic [63:0]   EN_SUPPORTED = 64'h0000_0000_0000_0D01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_index,
  input  logic [31:0] req_lo,
  input  logic [31:0] req_hi,
  input  logic        real_mode,
  input  logic [1:0]  cpl,
  input  logic        paging_on,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic        rsp_wack,
  output logic [31:0] rsp_lo,
  output logic [31:0] rsp_hi
);
  localparam int unsigned SW = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1;

  sel_e          sel;
  logic [SW-1:0] slot;
  logic          oor;
  logic [DW-1:0] wval;
  logic [DW-1:0] en_val, ad_val, rd_val;
  logic [HW-1:0] fc_val;
  logic          en_bad, fc_bad, ad_bad;
  logic          accept, priv_bad, gate_bad, rule_bad, fault;
  logic          commit_en, commit_fc, commit_ad;

  assign wval      = {req_hi, req_lo};
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  ctlreg_decode #(
    .IDX_LIMIT(IDX_LIMIT), .IDX_EN(IDX_EN), .IDX_FC(IDX_FC),
    .IDX_AB(IDX_AB), .NUM_ADDR(NUM_ADDR)
  ) u_dec (
    .index(req_index), .sel(sel), .slot(slot), .out_of_range(oor)
  );

  always_comb begin
    priv_bad = !real_mode && (cpl != 2'd0);
    gate_bad = priv_bad || oor || (sel == SEL_NONE);
    unique case (sel)
      SEL_ENABLE: rule_bad = en_bad;
      SEL_FEAT:   rule_bad = fc_bad;
      SEL_ADDR:   rule_bad = ad_bad;
      default:    rule_bad = 1'b0;
    endcase
    fault     = gate_bad || (req_write && rule_bad);
    commit_en = accept && req_write && !fault && (sel == SEL_ENABLE);
    commit_fc = accept && req_write && !fault && (sel == SEL_FEAT);
    commit_ad = accept && req_write && !fault && (sel == SEL_ADDR);
  end

  ctlreg_enable_reg #(.EN_SUPPORTED(EN_SUPPORTED)) u_en (
    .clk(clk), .rst_n(rst_n), .commit(commit_en), .wdata(wval),
    .paging_on(paging_on), .value(en_val), .bad(en_bad)
  );

  ctlreg_feat_reg u_fc (
    .clk(clk), .rst_n(rst_n), .commit(commit_fc), .wdata(req_lo),
    .value(fc_val), .bad(fc_bad)
  );

  ctlreg_addr_bank #(.NUM_ADDR(NUM_ADDR), .VA_MSB(VA_MSB)) u_ad (
    .clk(clk), .rst_n(rst_n), .commit(commit_ad), .slot(slot),
    .wdata(wval), .rdata(ad_val), .bad(ad_bad)
  );

  always_comb begin
    unique case (sel)
      SEL_ENABLE: rd_val = en_val;
      SEL_FEAT:   rd_val = {{(DW-HW){1'b0}}, fc_val};
      SEL_ADDR:   rd_val = ad_val;
      default:    rd_val = '0;
    endcase
    if (fault || req_write) rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_wack  <= 1'b0;
      rsp_lo    <= '0;
      rsp_hi    <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault;
      rsp_wack  <= req_write && !fault;
      rsp_lo    <= rd_val[HW-1:0];
      rsp_hi    <= rd_val[DW-1:HW];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctlreg_access_guard_chk.sv
module ctlreg_access_guard_chk #(
  parameter logic [29:0] IDX_LIMIT = 30'h0000_1000,
  parameter logic [31:0] IDX_AB    = 32'h0000_0100,
  parameter int unsigned VA_MSB    = 47
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_index,
  input logic [31:0] req_lo,
  input logic [31:0] req_hi,
  input logic        real_mode,
  input logic [1:0]  cpl,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic        rsp_wack,
  input logic [31:0] rsp_lo,
  input logic [31:0] rsp_hi
);
  logic acc;
  logic [63:0] wv;
  logic noncanon;
  assign acc      = req_valid && req_ready;
  assign wv       = {req_hi, req_lo};
  assign noncanon = !((&wv[63:VA_MSB]) || !(|wv[63:VA_MSB]));

  assert_priv_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !real_mode && (cpl != 2'd0) |=> rsp_valid && rsp_fault);

  assert_range_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_index[29:0] >= IDX_LIMIT) |=> rsp_valid && rsp_fault);

  assert_noncanon_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && (req_index == IDX_AB) && noncanon |=> rsp_fault && !rsp_wack);

  assert_read_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write |=> rsp_valid && !rsp_wack);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write |=> rsp_valid && (rsp_fault != rsp_wack));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_fault, rsp_wack, rsp_lo, rsp_hi}));
endmodule

bind ctlreg_access_guard ctlreg_access_guard_chk #(
  .IDX_LIMIT(IDX_LIMIT), .IDX_AB(IDX_AB), .VA_MSB(VA_MSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_index(req_index), .req_lo(req_lo), .req_hi(req_hi),
  .real_mode(real_mode), .cpl(cpl), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_fault(rsp_fault), .rsp_wack(rsp_wack), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
);

// File: tb/ctlreg_access_guard_test.sv
module ctlreg_access_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] I_EN = 32'h080, I_FC = 32'h03A, I_AB = 32'h100;
  localparam logic [63:0] SUP = 64'hD01;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, real_mode = 0, paging_on = 0, rsp_ready = 0;
  logic [31:0] req_index = 0, req_lo = 0, req_hi = 0;
  logic [1:0] cpl = 0;
  logic req_ready, rsp_valid, rsp_fault, rsp_wack;
  logic [31:0] rsp_lo, rsp_hi;

  int vectors = 0, fails = 0;
  logic [63:0] m_en = 0, m_ad [4];
  logic [31:0] m_fc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_access_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_lo(req_lo), .req_hi(req_hi),
    .real_mode(real_mode), .cpl(cpl), .paging_on(paging_on),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_wack(rsp_wack), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic bit canon(input logic [63:0] v);
    return (&v[63:47]) || !(|v[63:47]);
  endfunction

  // Bench model of the requirements; updates the model state on a legal write.
  task automatic model(input logic w, input logic [31:0] idx, input logic [63:0] v,
                       input logic rm, input logic [1:0] pl, input logic pg,
                       output logic flt, output logic [63:0] rd);
    int slot = -1;
    flt = 0; rd = 0;
    for (int i = 0; i < 4; i++) if (idx == I_AB + 32'(i)) slot = i;
    if (!rm && pl != 0) flt = 1;                       // R1
    else if (idx[29:0] >= 30'h1000) flt = 1;           // R2
    else if (idx == I_EN) begin
      if (w) begin
        if ((v & ~SUP) != 0) flt = 1;                  // R5
        else if (pg && v[8] != m_en[8]) flt = 1;       // R6
        else m_en = (v & SUP & ~64'h400) | (m_en & 64'h400); // R7
      end else rd = m_en;
    end else if (idx == I_FC) begin
      if (w) begin
        if (m_fc[0]) flt = 1;                          // R8
        else m_fc = v[31:0];
      end else rd = {32'h0, m_fc};
    end else if (slot >= 0) begin
      if (w) begin
        if (!canon(v)) flt = 1;                        // R9
        else m_ad[slot] = v;
      end else rd = m_ad[slot];
    end else flt = 1;                                  // R3
  endtask

  task automatic xact(input logic w, input logic [31:0] idx, input logic [31:0] lo, hi,
                      input logic rm, input logic [1:0] pl, input logic pg,
                      input int stall, input string tag);
    logic eflt; logic [63:0] erd;
    logic [65:0] snap;
    model(w, idx, {hi, lo}, rm, pl, pg, eflt, erd);
    @(negedge clk);
    req_valid = 1; req_write = w; req_index = idx; req_lo = lo; req_hi = hi;
    real_mode = rm; cpl = pl; paging_on = pg;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_fault == eflt && rsp_wack == (w && !eflt) &&
          {rsp_hi, rsp_lo} == erd, {tag, " R4 R10 response"},
          $sformatf("v%0b f%0b a%0b %h", rsp_valid, rsp_fault, rsp_wack, {rsp_hi, rsp_lo}),
          $sformatf("v1 f%0b a%0b %h", eflt, w && !eflt, erd));
    snap = {rsp_fault, rsp_wack, rsp_hi, rsp_lo};
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && {rsp_fault, rsp_wack, rsp_hi, rsp_lo} == snap,
            {tag, " R10 hold"}, $sformatf("v%0b r%0b", rsp_valid, req_ready), "v1 r0 stable");
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(!rsp_valid && req_ready, {tag, " R10 pop"},
          $sformatf("v%0b r%0b", rsp_valid, req_ready), "v0 r1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4; i++) m_ad[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11 reset idle", $sformatf("v%0b", rsp_valid), "v0");
    xact(0, I_EN, 0, 0, 1, 0, 0, 0, "R11 enable zero");
    xact(0, I_FC, 0, 0, 1, 0, 0, 0, "R11 feat zero");
    xact(0, I_AB + 3, 0, 0, 1, 0, 0, 1, "R11 addr zero");
    // R1 privilege
    xact(1, I_EN, 32'h1, 0, 0, 2'd3, 0, 0, "R1 user write");
    xact(0, I_EN, 0, 0, 0, 2'd1, 0, 2, "R1 ring1 read");
    xact(0, I_EN, 0, 0, 1, 2'd3, 0, 0, "R1 real mode ok");
    // R2 / R3 index
    xact(0, 32'h0000_1000, 0, 0, 0, 0, 0, 0, "R2 at limit");
    xact(1, 32'hC000_1ABC, 1, 0, 0, 0, 0, 0, "R2 high bits");
    xact(1, 32'h4000_0080, 1, 0, 0, 0, 0, 0, "R3 alias write");
    xact(0, 32'h0000_0104, 0, 0, 0, 0, 0, 0, "R3 unknown read");
    xact(0, I_EN, 0, 0, 0, 0, 0, 0, "R3 enable untouched");
    // R4 / R9
    xact(1, I_AB + 1, 32'hDEAD_BEEF, 32'hFFFF_8123, 0, 0, 0, 0, "R9 canonical high");
    xact(0, I_AB + 1, 0, 0, 0, 0, 0, 3, "R4 split read");
    xact(1, I_AB + 1, 32'h1, 32'h0000_8000, 0, 0, 0, 0, "R9 noncanonical");
    xact(0, I_AB + 1, 0, 0, 0, 0, 0, 0, "R9 value kept");
    // R5 / R6 / R7
    xact(1, I_EN, 32'h2, 0, 0, 0, 0, 0, "R5 unsupported bit");
    xact(1, I_EN, 32'h101, 0, 0, 0, 0, 0, "R6 set lme no paging");
    xact(1, I_EN, 32'h001, 0, 0, 0, 1, 0, "R6 clear lme paging");
    xact(1, I_EN, 32'h901, 0, 0, 0, 1, 0, "R6 same lme paging");
    xact(1, I_EN, 32'h500, 0, 0, 0, 0, 0, "R7 active bit write");
    xact(0, I_EN, 0, 0, 0, 0, 1, 0, "R7 active bit reads 0");
    // R8 lock
    xact(1, I_FC, 32'h4, 32'hFFFF, 0, 0, 0, 0, "R8 unlocked write");
    xact(0, I_FC, 0, 0, 0, 0, 0, 0, "R8 high half zero");
    xact(1, I_FC, 32'h5, 0, 0, 0, 0, 0, "R8 set lock");
    xact(1, I_FC, 32'h0, 0, 0, 0, 0, 0, "R8 locked write");
    xact(0, I_FC, 0, 0, 0, 0, 0, 0, "R8 value sealed");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] idx, lo, hi;
      int k = $urandom_range(0, 9);
      case (k)
        0, 1: idx = I_EN;
        2:    idx = I_FC;
        3, 4, 5: idx = I_AB + 32'($urandom_range(0, 4));
        6:    idx = 32'h1000 + ($urandom & 32'hFFFF);
        7:    idx = $urandom & 32'h0FFF;
        default: idx = $urandom;
      endcase
      lo = $urandom; hi = $urandom;
      if (idx == I_EN && $urandom_range(0, 2) != 0) begin lo = lo & 32'hD01; hi = 0; end
      if ($urandom_range(0, 3) != 0) hi = {{17{lo[31] ^ hi[15]}} , hi[14:0]};
      if ($urandom_range(0, 1) == 1) hi = {{17{hi[15]}}, hi[14:0]};
      xact(logic'($urandom_range(0, 1)), idx, lo, hi,
           logic'($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd0,
           logic'($urandom_range(0, 1)), $urandom_range(0, 2), "R4 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule